// File: doc/BRIEF.md
# Condition Flags and Next-PC Controller

This block sits beside the register file and program counter of a small 16-bit load/store processor. It keeps the three condition flags (negative, zero, positive) and works out, for every control-flow instruction, where the program counter goes next. The flags follow the value the datapath writes into a general register. Branches compare those flags against a three-bit mask in the instruction. Jumps may save a return address. A trap fetches its handler address from a table held in the lowest 256 words of memory.

An instruction is offered on `instr` with `instr_valid`. It is accepted in a cycle where `instr_ready` is also high. The outputs for an accepted instruction (`pc_load`, `pc_next`, `link_we`, `link_data`, `vec_rd`, `vec_addr`) are combinational in that same cycle. The only back-pressure comes from a trap. In the cycle after a trap is accepted, `instr_ready` is low, the block loads the PC from `vec_data`, and an offered instruction is neither accepted nor acted on. The caller holds it until `instr_ready` returns high. Reading the register file, ALU work and memory timing are outside this block. The block receives the base register value on `base_val` and R7 on `r7_val`, and the vector word arrives on `vec_data` one cycle after `vec_rd`.

Top module: `cc_npc_unit`

## Requirements
- R1: While reset is held and after it is released, the flags are Z=1, N=0 and P=0, and `instr_ready` is 1.
- R2: When `gpr_wr_en` is high at a clock edge, the flags take a new value from `gpr_wr_data` in the next cycle, with exactly one flag set: N if bit 15 is 1, Z if the value is zero, and P otherwise. Without a write, the flags hold.
- R3: A branch has opcode 0000 in bits 15:12 and mask bits n, z, p in bits 11, 10 and 9. It is taken when (N&n)|(Z&z)|(P&p) is 1. In that case `pc_load`=1 and `pc_next` is `{pc_inc[15:9], instr[8:0]}`.
- R4: An untaken branch, including one whose mask is 000, gives `pc_load`=0 with `pc_next` equal to `pc_inc`.
- R5: A direct jump has opcode 0100. It always loads `{pc_inc[15:9], instr[8:0]}`. When the link bit (bit 11) is 1, it also raises `link_we` with `link_data`=`pc_inc`, in the same cycle.
- R6: A register jump has opcode 1100. It loads `base_val` plus bits 5:0, zero-extended, with the sum wrapping modulo 2^16. It links exactly as R5 does.
- R7: A return has opcode 1101. It loads `pc_next`=`r7_val` and does not link.
- R8: A trap has opcode 1111. In the cycle it is accepted, it raises `vec_rd` with `vec_addr`=`{8'h00, instr[7:0]}` and links `pc_inc`, with `pc_load`=0. In the next cycle, `pc_load`=1, `pc_next`=`vec_data`, `instr_ready`=0, and there is no link and no read. After that, `instr_ready` is 1 again.
- R9: All other opcodes, and any cycle with no accepted instruction, give `pc_load`=0, `link_we`=0, `vec_rd`=0 and `pc_next`=`pc_inc`.
- R10: Saving a return address does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Instruction can be accepted (low in the second trap cycle) |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter |
| base_val | input | 16 | Register value selected by bits 8:6 |
| r7_val | input | 16 | Current contents of R7 |
| vec_data | input | 16 | Memory word returned for the trap vector read |
| gpr_wr_en | input | 1 | A general register is written this cycle |
| gpr_wr_data | input | 16 | Value written to the general register |
| pc_next | output | 16 | Next program counter value |
| pc_load | output | 1 | Load `pc_next` into the PC |
| link_we | output | 1 | Write `link_data` into R7 |
| link_data | output | 16 | Return address for R7 |
| vec_rd | output | 1 | Trap vector memory read request |
| vec_addr | output | 16 | Trap vector address |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
Next-PC, link and vector-read results are combinational. They are due in the cycle an instruction is accepted. A trap's PC load is due exactly one cycle later, and the flags change one cycle after a register write. The bench drives on the falling edge and samples a nanosecond later. It writes the flag-setting value one cycle before offering each instruction, so every flag and PC result is read in the cycle where it becomes due and not in the cycle before.

// File: rtl/cc_npc_pkg.sv
package cc_npc_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_BRANCH = 4'b0000,
    OPC_JDIR   = 4'b0100,
    OPC_JREG   = 4'b1100,
    OPC_RETURN = 4'b1101,
    OPC_TRAP   = 4'b1111
  } ctl_opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_flags_t;

endpackage

// File: rtl/cc_npc_flags.sv
module cc_npc_flags
  import cc_npc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cc_flags_t     flags
);

  cc_flags_t next_flags;

  always_comb begin
    next_flags.n = wr_data[DW-1];
    next_flags.z = (wr_data == '0);
    next_flags.p = !wr_data[DW-1] && (wr_data != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    end else if (wr_en) begin
      flags <= next_flags;
    end
  end

endmodule

// File: rtl/cc_npc_target.sv
module cc_npc_target
  import cc_npc_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned OFFW  = 9,
  parameter int unsigned BASEW = 6,
  parameter int unsigned VECW  = 8
) (
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] r7_val,
  input  cc_flags_t     flags,
  output logic          take,
  output logic [DW-1:0] target,
  output logic          link,
  output logic          is_trap,
  output logic [DW-1:0] vaddr
);

  localparam int unsigned OPC_LSB  = DW - OPC_W;
  localparam int unsigned LINK_BIT = OPC_LSB - 1;

  ctl_opc_e      opc;
  logic [2:0]    mask;
  logic          link_bit;
  logic          br_hit;
  logic [DW-1:0] direct_tgt;
  logic [DW-1:0] index_tgt;

  always_comb begin
    opc        = ctl_opc_e'(instr[DW-1:OPC_LSB]);
    mask       = instr[LINK_BIT -: 3];
    link_bit   = instr[LINK_BIT];
    br_hit     = |(mask & {flags.n, flags.z, flags.p});
    direct_tgt = {pc_inc[DW-1:OFFW], instr[OFFW-1:0]};
    index_tgt  = base_val + {{(DW-BASEW){1'b0}}, instr[BASEW-1:0]};
    vaddr      = {{(DW-VECW){1'b0}}, instr[VECW-1:0]};

    take    = 1'b0;
    target  = pc_inc;
    link    = 1'b0;
    is_trap = 1'b0;

    case (opc)
      OPC_BRANCH: begin
        take   = br_hit;
        target = br_hit ? direct_tgt : pc_inc;
      end
      OPC_JDIR: begin
        take   = 1'b1;
        target = direct_tgt;
        link   = link_bit;
      end
      OPC_JREG: begin
        take   = 1'b1;
        target = index_tgt;
        link   = link_bit;
      end
      OPC_RETURN: begin
        take   = 1'b1;
        target = r7_val;
      end
      OPC_TRAP: begin
        link    = 1'b1;
        is_trap = 1'b1;
      end
      default: begin
        take = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cc_npc_trap_seq.sv
module cc_npc_trap_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_go,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= trap_go && !pending;
    end
  end

endmodule

// File: rtl/cc_npc_unit.sv
module cc_npc_unit
  import cc_npc_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned OFFW  = 9,
  parameter int unsigned BASEW = 6,
  parameter int unsigned VECW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] r7_val,
  input  logic [DW-1:0] vec_data,
  input  logic          gpr_wr_en,
  input  logic [DW-1:0] gpr_wr_data,
  output logic [DW-1:0] pc_next,
  output logic          pc_load,
  output logic          link_we,
  output logic [DW-1:0] link_data,
  output logic          vec_rd,
  output logic [DW-1:0] vec_addr,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_p
);

  cc_flags_t     flags;
  logic          take;
  logic [DW-1:0] target;
  logic          link;
  logic          is_trap;
  logic          pending;
  logic          accept;

  cc_npc_flags #(.DW(DW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (gpr_wr_en),
    .wr_data (gpr_wr_data),
    .flags   (flags)
  );

  cc_npc_target #(
    .DW(DW), .OFFW(OFFW), .BASEW(BASEW), .VECW(VECW)
  ) u_target (
    .instr    (instr),
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .r7_val   (r7_val),
    .flags    (flags),
    .take     (take),
    .target   (target),
    .link     (link),
    .is_trap  (is_trap),
    .vaddr    (vec_addr)
  );

  cc_npc_trap_seq u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_go (accept && is_trap),
    .pending (pending)
  );

  always_comb begin
    instr_ready = !pending;
    accept      = instr_valid && instr_ready;
    pc_load     = pending || (accept && take);
    if (pending) begin
      pc_next = vec_data;
    end else if (accept && take) begin
      pc_next = target;
    end else begin
      pc_next = pc_inc;
    end
    link_we   = accept && link;
    link_data = pc_inc;
    vec_rd    = accept && is_trap;
    flag_n    = flags.n;
    flag_z    = flags.z;
    flag_p    = flags.p;
  end

endmodule

// File: rtl/cc_npc_unit_chk.sv
module cc_npc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        instr_ready,
  input logic [15:0] pc_inc,
  input logic [15:0] pc_next,
  input logic        pc_load,
  input logic        link_we,
  input logic        vec_rd,
  input logic        gpr_wr_en,
  input logic [15:0] gpr_wr_data,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_p
);

  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  p_flag_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_wr_en |=> (flag_z == ($past(gpr_wr_data) == 16'h0000)) &&
                  (flag_n == $past(gpr_wr_data[15])));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gpr_wr_en |=> $stable({flag_n, flag_z, flag_p}));

  p_trap_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (pc_load && !instr_ready && !link_we && !vec_rd));

  p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> instr_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && instr_ready) |->
      (!pc_load && !link_we && !vec_rd && pc_next == pc_inc));

endmodule

bind cc_npc_unit cc_npc_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .pc_inc      (pc_inc),
  .pc_next     (pc_next),
  .pc_load     (pc_load),
  .link_we     (link_we),
  .vec_rd      (vec_rd),
  .gpr_wr_en   (gpr_wr_en),
  .gpr_wr_data (gpr_wr_data),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_p      (flag_p)
);

// File: tb/cc_npc_unit_bench.sv
`timescale 1ns/1ps
module cc_npc_unit_bench;

  typedef struct packed {
    logic [15:0] wr;
    logic [15:0] ins;
    logic [15:0] pc;
    logic [15:0] base;
    logic        ld;
    logic [15:0] nxt;
    logic        lk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam logic [15:0] R7V = 16'h7777;
  localparam vec_t VT [NV] = '{
    '{16'h8001, 16'h09F3, 16'h3A05, 16'h1000, 1'b1, 16'h3BF3, 1'b0, 4'd3}, // R3 n hit
    '{16'h0005, 16'h09F3, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd4}, // R4 n miss
    '{16'h0005, 16'h03F3, 16'h3A05, 16'h1000, 1'b1, 16'h3BF3, 1'b0, 4'd3}, // R3 p hit
    '{16'h0000, 16'h04F0, 16'h3A05, 16'h1000, 1'b1, 16'h3AF0, 1'b0, 4'd3}, // R3 z hit
    '{16'h0000, 16'h00F0, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd4}, // R4 mask 000
    '{16'h0005, 16'h0C10, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd4}, // R4 nz vs P
    '{16'h8001, 16'h0E10, 16'h3A05, 16'h1000, 1'b1, 16'h3A10, 1'b0, 4'd3}, // R3 nzp
    '{16'h0000, 16'h0E01, 16'hFFFF, 16'h1000, 1'b1, 16'hFE01, 1'b0, 4'd3}, // R3 high page
    '{16'h0005, 16'h4055, 16'h3A05, 16'h1000, 1'b1, 16'h3A55, 1'b0, 4'd5}, // R5 no link
    '{16'h0005, 16'h4855, 16'h3A05, 16'h1000, 1'b1, 16'h3A55, 1'b1, 4'd5}, // R5 link
    '{16'h0005, 16'hC03F, 16'h3A05, 16'h1000, 1'b1, 16'h103F, 1'b0, 4'd6}, // R6 no link
    '{16'h8001, 16'hC83F, 16'h3A05, 16'h1000, 1'b1, 16'h103F, 1'b1, 4'd6}, // R6 link
    '{16'h0005, 16'hC020, 16'h3A05, 16'hFFF0, 1'b1, 16'h0010, 1'b0, 4'd6}, // R6 wrap
    '{16'h0005, 16'hD800, 16'h3A05, 16'h1000, 1'b1, 16'h7777, 1'b0, 4'd7}, // R7
    '{16'h0005, 16'h1234, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd9}, // R9 alu op
    '{16'h0000, 16'h2000, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd9}, // R9 load op
    '{16'h8001, 16'h7E3F, 16'h3A05, 16'h1000, 1'b0, 16'h3A05, 1'b0, 4'd9}  // R9 store op
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = '0;
  logic [15:0] pc_inc = '0;
  logic [15:0] base_val = '0;
  logic [15:0] r7_val = R7V;
  logic [15:0] vec_data = '0;
  logic        gpr_wr_en = 1'b0;
  logic [15:0] gpr_wr_data = '0;
  logic [15:0] pc_next;
  logic        pc_load;
  logic        link_we;
  logic [15:0] link_data;
  logic        vec_rd;
  logic [15:0] vec_addr;
  logic        flag_n, flag_z, flag_p;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  cc_npc_unit u_cc_npc_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .pc_inc(pc_inc), .base_val(base_val), .r7_val(r7_val),
    .vec_data(vec_data), .gpr_wr_en(gpr_wr_en), .gpr_wr_data(gpr_wr_data),
    .pc_next(pc_next), .pc_load(pc_load), .link_we(link_we), .link_data(link_data),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] flags_of(input logic [15:0] v);
    if (v[15])        return 3'b100;
    else if (v == 0)  return 3'b010;
    else              return 3'b001;
  endfunction

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "flags in reset", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "flags after reset", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);
    chk("R1", "ready after reset", {15'd0, instr_ready}, 16'h0001);
    chk("R9", "idle pc_load", {15'd0, pc_load}, 16'h0000);

    // table walk: R2 flags, then R3..R7, R9 outcome
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_valid = 1'b0;
      gpr_wr_en   = 1'b1;
      gpr_wr_data = VT[i].wr;
      @(negedge clk);
      gpr_wr_en   = 1'b0;
      instr       = VT[i].ins;
      pc_inc      = VT[i].pc;
      base_val    = VT[i].base;
      instr_valid = 1'b1;
      #1;
      chk("R2", "flags", {13'd0, flag_n, flag_z, flag_p}, {13'd0, flags_of(VT[i].wr)});
      chk($sformatf("R%0d", VT[i].req), "pc_load", {15'd0, pc_load}, {15'd0, VT[i].ld});
      chk($sformatf("R%0d", VT[i].req), "pc_next", pc_next, VT[i].nxt);
      chk($sformatf("R%0d", VT[i].req), "link_we", {15'd0, link_we}, {15'd0, VT[i].lk});
      if (VT[i].lk)
        chk($sformatf("R%0d", VT[i].req), "link_data", link_data, VT[i].pc);
      chk($sformatf("R%0d", VT[i].req), "vec_rd", {15'd0, vec_rd}, 16'h0000);
    end

    // R10: a linking jump with no register write leaves the flags alone
    @(negedge clk);
    instr_valid = 1'b0;
    gpr_wr_en = 1'b1;
    gpr_wr_data = 16'h0000;
    @(negedge clk);
    gpr_wr_en = 1'b0;
    instr = 16'h4801;
    pc_inc = 16'h0123;
    instr_valid = 1'b1;
    #1;
    chk("R10", "link raised", {15'd0, link_we}, 16'h0001);
    held = {flag_n, flag_z, flag_p};
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    chk("R10", "flags after link", {13'd0, flag_n, flag_z, flag_p}, {13'd0, held});

    // R8: trap sequence, with an instruction held during the busy cycle
    @(negedge clk);
    instr = 16'hF025;
    pc_inc = 16'h3A05;
    instr_valid = 1'b1;
    #1;
    chk("R8", "vec_rd", {15'd0, vec_rd}, 16'h0001);
    chk("R8", "vec_addr", vec_addr, 16'h0025);
    chk("R8", "trap link_we", {15'd0, link_we}, 16'h0001);
    chk("R8", "trap link_data", link_data, 16'h3A05);
    chk("R8", "first pc_load", {15'd0, pc_load}, 16'h0000);
    @(negedge clk);
    instr = 16'hD000;
    vec_data = 16'h0400;
    #1;
    chk("R8", "second pc_load", {15'd0, pc_load}, 16'h0001);
    chk("R8", "second pc_next", pc_next, 16'h0400);
    chk("R8", "busy ready", {15'd0, instr_ready}, 16'h0000);
    chk("R8", "second link_we", {15'd0, link_we}, 16'h0000);
    chk("R8", "second vec_rd", {15'd0, vec_rd}, 16'h0000);
    @(negedge clk);
    #1;
    chk("R8", "ready restored", {15'd0, instr_ready}, 16'h0001);
    chk("R7", "held return accepted", pc_next, R7V);

    // R9: a taken-looking branch offered without valid does nothing
    @(negedge clk);
    instr_valid = 1'b0;
    instr = 16'h0E44;
    pc_inc = 16'h5555;
    #1;
    chk("R9", "no valid pc_load", {15'd0, pc_load}, 16'h0000);
    chk("R9", "no valid pc_next", pc_next, 16'h5555);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule